// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block lets a two-wire bus master (I2C, standard or fast mode) program a small bank of amplifier control settings. The bank holds three 5-bit attenuation settings and one 8-bit enable/mode byte. Each setting appears on a parallel output port, so the analog blocks nearby see the stored value directly. The block samples SCL and SDA with the system clock through synchronizers and recovers START, repeated START and STOP from those samples. It answers to one fixed 7-bit address. It pulls SDA low only while acknowledging or while returning a 0 data bit, and otherwise leaves the line released.

An internal 8-bit register pointer carries every access. A write frame sets the pointer with its first byte after the address, and every later byte goes to the register under the pointer. After each data byte the pointer advances by one, whether the byte was written or read. A read that follows a fresh START always starts at register 0. A read that follows a repeated START continues from wherever an earlier write left the pointer, so a master can fetch any single register by sending a pointer byte and then a repeated START. Registers 0 and those above 4 do not exist. The block acknowledges writes to them and discards the data, and reads from them return zero.

Top module: `i2c_ctrl_regs`

## Requirements
- R1: The block acknowledges (drives SDA low during the ninth clock) an address byte of 0x9A (write) or 0x9B (read). It does not acknowledge any other address byte and ignores the rest of that frame.
- R2: In a write frame, the byte after the address loads the pointer and each following byte is stored at the pointer. The block acknowledges every one of these bytes.
- R3: The pointer increments by one after each data byte written or read, so several registers can be accessed in one frame.
- R4: A read addressed right after a START that followed a STOP (or reset) clears the pointer, so the first byte returned is register 0x00.
- R5: A read addressed after a repeated START keeps the pointer set earlier in the frame, so the first byte returned is that register.
- R6: When the master answers a read byte with a NACK (SDA high on the ninth clock), the block releases SDA and drives nothing more until the next START.
- R7: A STOP ends any transfer at once. A data byte cut short by a STOP writes nothing, and SDA is released.
- R8: Registers 0x01, 0x02 and 0x03 hold the speaker, left headphone and right headphone attenuation codes in bits 4:0. Bits 7:5 read as zero, and each value appears on its own output port.
- R9: Register 0x04 is the control byte. Bit 7 is active-low shutdown, bit 6 is bypass enable, bit 5 always reads zero (writes to it are dropped), bit 4 enables input B, bit 3 enables input A, bit 2 enables the left speaker, bit 1 enables the right speaker and bit 0 enables the headphone. It appears on `ctrl_o`.
- R10: After reset all three attenuation codes are 0 (mute) and the control byte is 0x40 (bypass enabled, in shutdown).
- R11: Writes to register 0x00 or to any register above 0x04 are acknowledged and discarded. Reads from those registers return 0x00.
- R12: SDA is only ever pulled low (never driven high), and the block changes its SDA drive only while SCL is low, except when it releases SDA on START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| vol_spk_o | output | 5 | Speaker attenuation code (register 0x01) |
| vol_hpl_o | output | 5 | Left headphone attenuation code (register 0x02) |
| vol_hpr_o | output | 5 | Right headphone attenuation code (register 0x03) |
| ctrl_o | output | 8 | Control byte (register 0x04) |

## Verification
The bench targets the pointer corner cases. A read after a fresh START must return register 0, and a read after a repeated START must return the preset register. A design that confused the two would return the wrong register on either path. Further tests cover writes that run past register 4 and stray writes to register 0, which a design without address guarding would let land in a real register. A STOP in the middle of a data byte must not commit a half-shifted value. The bench also keeps clocking after a master NACK: a slave that kept driving would corrupt bytes that another device on the bus is meant to own.

// File: rtl/i2c_ctrl_pkg.sv
// Shared types and constants for the two-wire control register slave.
// Assumes an 8-bit register pointer and byte-wide bus transfers.
package i2c_ctrl_pkg;

    // Phase of the frame handler.
    typedef enum logic [2:0] {
        FS_IDLE,   // not addressed, waiting for START
        FS_ADDR,   // shifting in the address byte
        FS_PTR,    // shifting in the pointer byte
        FS_WDATA,  // shifting in a data byte
        FS_RDATA,  // shifting out a data byte
        FS_MACK,   // master acknowledge slot after a read byte
        FS_SACK    // slave acknowledge slot
    } frame_st_t;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_line_sync.sv
// Brings SCL and SDA into the clock domain and derives bus events.
// Assumes the bus is at least a few times slower than clk; all event
// outputs are single-cycle pulses aligned with the synchronized lines.
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_d;
    logic                   sda_d;

    // Synchronizer chains plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[SYNC_STAGES-1];
            sda_d    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    // Event decode: SDA moving while SCL stays high marks START or STOP.
    always_comb begin
        scl_rise  = scl_s && !scl_d;
        scl_fall  = !scl_s && scl_d;
        start_det = scl_s && scl_d && sda_d && !sda_s;
        stop_det  = scl_s && scl_d && !sda_d && sda_s;
    end
endmodule

// File: rtl/i2c_frame_ctrl.sv
// Byte-level frame handler: address match, pointer load, write strobes,
// read shifting and acknowledge slots. Acts on synchronized bus events;
// samples SDA on SCL rise and changes its SDA drive only on SCL fall.
module i2c_frame_ctrl
    import i2c_ctrl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h4D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] ptr_o,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe
);
    frame_st_t         st;
    frame_st_t         ack_src;
    logic [BYTE_W-1:0] shreg;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] ptr;
    logic              rw;
    logic              in_frame;
    logic              rep;
    logic              nack;

    assign ptr_o = ptr;

    // Frame sequencing; STOP and START take priority over any phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= FS_IDLE;
            ack_src  <= FS_IDLE;
            shreg    <= '0;
            bitcnt   <= '0;
            ptr      <= '0;
            rw       <= 1'b0;
            in_frame <= 1'b0;
            rep      <= 1'b0;
            nack     <= 1'b0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (stop_det) begin
                st       <= FS_IDLE;
                sda_oe   <= 1'b0;
                in_frame <= 1'b0;
            end else if (start_det) begin
                st       <= FS_ADDR;
                bitcnt   <= '0;
                sda_oe   <= 1'b0;
                rep      <= in_frame;
                in_frame <= 1'b1;
            end else begin
                unique case (st)
                    FS_ADDR, FS_PTR, FS_WDATA: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt  <= '0;
                            ack_src <= st;
                            if (st == FS_ADDR) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    rw     <= shreg[0];
                                    sda_oe <= 1'b1;
                                    st     <= FS_SACK;
                                    if (shreg[0] && !rep) ptr <= '0;
                                end else begin
                                    st <= FS_IDLE;
                                end
                            end else if (st == FS_PTR) begin
                                ptr    <= shreg;
                                sda_oe <= 1'b1;
                                st     <= FS_SACK;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= shreg;
                                ptr     <= ptr + 8'd1;
                                sda_oe  <= 1'b1;
                                st      <= FS_SACK;
                            end
                        end
                    end
                    FS_SACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (ack_src == FS_ADDR && rw) begin
                                shreg  <= rd_data;
                                sda_oe <= !rd_data[7];
                                st     <= FS_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= (ack_src == FS_ADDR) ? FS_PTR : FS_WDATA;
                            end
                        end
                    end
                    FS_RDATA: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr + 8'd1;
                                bitcnt <= '0;
                                st     <= FS_MACK;
                            end else begin
                                sda_oe <= !shreg[6];
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                    FS_MACK: begin
                        if (scl_rise) begin
                            nack <= sda_s;
                        end else if (scl_fall) begin
                            if (nack) begin
                                st <= FS_IDLE;
                            end else begin
                                shreg  <= rd_data;
                                sda_oe <= !rd_data[7];
                                st     <= FS_RDATA;
                            end
                        end
                    end
                    default: begin
                        st <= FS_IDLE;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_reg_bank.sv
// Register storage with a write strobe and a combinational read port.
// Registers 1..NUM_VOL hold VOL_W-bit codes; register NUM_VOL+1 holds the
// control byte; every other address reads zero and drops writes.
module i2c_reg_bank
    import i2c_ctrl_pkg::*;
#(
    parameter int                NUM_VOL   = 3,
    parameter int                VOL_W     = 5,
    parameter logic [BYTE_W-1:0] CTRL_RST  = 8'h40,
    parameter logic [BYTE_W-1:0] CTRL_MASK = 8'hDF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [BYTE_W-1:0]        wr_addr,
    input  logic [BYTE_W-1:0]        wr_data,
    input  logic [BYTE_W-1:0]        rd_addr,
    output logic [BYTE_W-1:0]        rd_data,
    output logic [NUM_VOL*VOL_W-1:0] vol_flat,
    output logic [BYTE_W-1:0]        ctrl
);
    localparam logic [BYTE_W-1:0] CTRL_ADDR = BYTE_W'(NUM_VOL + 1);

    logic [VOL_W-1:0] vol_q [NUM_VOL];

    for (genvar g = 0; g < NUM_VOL; g++) begin : g_vol
        // One attenuation register per output, reset to mute.
        always_ff @(posedge clk) begin
            if (!rst_n)
                vol_q[g] <= '0;
            else if (wr_en && wr_addr == BYTE_W'(g + 1))
                vol_q[g] <= wr_data[VOL_W-1:0];
        end
        assign vol_flat[g*VOL_W +: VOL_W] = vol_q[g];
    end

    // Control byte with its always-zero bit masked on write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= CTRL_RST;
        else if (wr_en && wr_addr == CTRL_ADDR)
            ctrl <= wr_data & CTRL_MASK;
    end

    // Read mux; unmapped addresses return zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_VOL; i++) begin
            if (rd_addr == BYTE_W'(i + 1))
                rd_data = {{(BYTE_W-VOL_W){1'b0}}, vol_q[i]};
        end
        if (rd_addr == CTRL_ADDR)
            rd_data = ctrl;
    end
endmodule

// File: rtl/i2c_ctrl_regs.sv
// Top of the two-wire control register slave. Ties the line synchronizer,
// frame handler and register bank together and exposes the register
// contents as parallel outputs. SDA is open-drain: sda_oe_o=1 pulls low.
module i2c_ctrl_regs
    import i2c_ctrl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h4D,
    parameter int         SYNC_STAGES = 2,
    parameter int         VOL_W       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    output logic [VOL_W-1:0] vol_spk_o,
    output logic [VOL_W-1:0] vol_hpl_o,
    output logic [VOL_W-1:0] vol_hpr_o,
    output logic [7:0]       ctrl_o
);
    localparam int NUM_VOL = 3;

    logic                     scl_s;
    logic                     sda_s;
    logic                     scl_rise;
    logic                     scl_fall;
    logic                     start_det;
    logic                     stop_det;
    logic [BYTE_W-1:0]        rd_data;
    logic [BYTE_W-1:0]        ptr;
    logic                     wr_en;
    logic [BYTE_W-1:0]        wr_addr;
    logic [BYTE_W-1:0]        wr_data;
    logic [NUM_VOL*VOL_W-1:0] vol_flat;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    i2c_frame_ctrl #(.DEV_ADDR(DEV_ADDR)) u_frame (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .ptr_o(ptr), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sda_oe(sda_oe_o)
    );

    i2c_reg_bank #(.NUM_VOL(NUM_VOL), .VOL_W(VOL_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data),
        .vol_flat(vol_flat), .ctrl(ctrl_o)
    );

    assign vol_spk_o = vol_flat[0*VOL_W +: VOL_W];
    assign vol_hpl_o = vol_flat[1*VOL_W +: VOL_W];
    assign vol_hpr_o = vol_flat[2*VOL_W +: VOL_W];
endmodule

// File: rtl/i2c_ctrl_regs_chk.sv
// Property checker for the control register slave, bound to the top.
// Observes synchronized bus events, the write strobe and the outputs.
module i2c_ctrl_regs_chk #(
    parameter int VOL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sda_oe,
    input logic             scl_s,
    input logic             start_det,
    input logic             stop_det,
    input logic             wr_en,
    input logic [7:0]       wr_addr,
    input logic [VOL_W-1:0] vol_spk,
    input logic [VOL_W-1:0] vol_hpl,
    input logic [VOL_W-1:0] vol_hpr,
    input logic [7:0]       ctrl
);
    logic [3*VOL_W+7:0] regs_all;
    assign regs_all = {vol_spk, vol_hpl, vol_hpr, ctrl};

    // R10: reset leaves mute codes and bypass-enabled control byte.
    p_reset_vals_r10: assert property (@(posedge clk)
        !rst_n |=> (vol_spk == '0 && vol_hpl == '0 && vol_hpr == '0 && ctrl == 8'h40));

    // R2: register contents move only on a write strobe.
    p_write_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_all));

    // R11: strobes aimed at unmapped registers leave everything untouched.
    p_reserved_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == 8'd0 || wr_addr > 8'd4)) |=> $stable(regs_all));

    // R12: SDA drive is held while SCL stays high, outside START/STOP.
    p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

    // R7: STOP releases the data line.
    p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
endmodule

bind i2c_ctrl_regs i2c_ctrl_regs_chk #(.VOL_W(VOL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .scl_s(scl_s),
    .start_det(start_det), .stop_det(stop_det), .wr_en(wr_en),
    .wr_addr(wr_addr), .vol_spk(vol_spk_o), .vol_hpl(vol_hpl_o),
    .vol_hpr(vol_hpr_o), .ctrl(ctrl_o)
);

// File: tb/i2c_ctrl_regs_tb.sv
// Bench: bus master tasks, a behavioural register model and a per-clock
// comparison of the parallel outputs against that model.
module i2c_ctrl_regs_tb;
    localparam int Q = 10;   // clocks per SCL half phase step

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe_o;
    logic [4:0] vol_spk_o, vol_hpl_o, vol_hpr_o;
    logic [7:0] ctrl_o;
    logic       bus_sda;

    int   checks = 0;
    int   fails = 0;
    bit   chk_en = 1'b0;
    bit   done = 1'b0;
    logic [7:0] mreg [5];
    int   mptr = 0;
    int   r12_viol = 0;
    logic prev_scl = 1'b1;
    logic prev_oe = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    assign bus_sda = m_sda & ~sda_oe_o;

    i2c_ctrl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
        .sda_oe_o(sda_oe_o), .vol_spk_o(vol_spk_o), .vol_hpl_o(vol_hpl_o),
        .vol_hpr_o(vol_hpr_o), .ctrl_o(ctrl_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_rd(input int p);
        return (p >= 1 && p <= 4) ? mreg[p] : 8'h00;
    endfunction

    // Model write: R8 masks volumes to 5 bits, R9 drops bit 5, R11 drops unmapped.
    function automatic void model_wr(input int p, input logic [7:0] d);
        if (p >= 1 && p <= 3) mreg[p] = d & 8'h1F;
        else if (p == 4) mreg[p] = d & 8'hDF;
    endfunction

    // Per-clock comparison of outputs with the model (R8, R9, R10).
    always @(negedge clk) begin
        if (chk_en && !done) begin
            check(vol_spk_o == mreg[1][4:0], "R8 spk", vol_spk_o, mreg[1]);
            check(vol_hpl_o == mreg[2][4:0], "R8 hpl", vol_hpl_o, mreg[2]);
            check(vol_hpr_o == mreg[3][4:0], "R8 hpr", vol_hpr_o, mreg[3]);
            check(ctrl_o == mreg[4], "R9 ctrl", ctrl_o, mreg[4]);
        end
        // R12 monitor: drive must not move while SCL is held high.
        if (rst_n && m_scl && prev_scl && sda_oe_o != prev_oe) r12_viol++;
        prev_scl = m_scl;
        prev_oe = sda_oe_o;
    end

    task automatic half();
        repeat (Q) @(posedge clk);
    endtask

    task automatic do_start();
        if (!m_scl) begin
            m_sda = 1'b1; half(); m_scl = 1'b1; half();
        end
        m_sda = 1'b0; half(); m_scl = 1'b0; half();
    endtask

    task automatic do_stop();
        m_sda = 1'b0; half(); m_scl = 1'b1; half(); m_sda = 1'b1; half();
    endtask

    // Sends one byte; commit=1 applies it to the model as a data write.
    task automatic send_byte(input logic [7:0] b, input bit commit, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; half(); m_scl = 1'b1; half(); m_scl = 1'b0;
        end
        if (commit) chk_en = 1'b0;
        m_sda = 1'b1; half();
        if (commit) begin
            model_wr(mptr, b);
            mptr = (mptr + 1) & 255;
            chk_en = 1'b1;
        end
        m_scl = 1'b1; half();
        ack = (bus_sda == 1'b0);
        m_scl = 1'b0;
    endtask

    // Receives one byte, then answers with ACK (mack=1) or NACK.
    task automatic recv_byte(input bit mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; half(); m_scl = 1'b1; half(); b[i] = bus_sda; m_scl = 1'b0;
        end
        m_sda = mack ? 1'b0 : 1'b1; half(); m_scl = 1'b1; half(); m_scl = 1'b0;
        half(); m_sda = 1'b1;
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        bit         ack;
        logic [7:0] rb;
        mreg[0] = 8'h00; mreg[1] = 8'h00; mreg[2] = 8'h00; mreg[3] = 8'h00; mreg[4] = 8'h40;
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        // R10: reset values at the ports.
        check(vol_spk_o == 5'd0 && vol_hpl_o == 5'd0 && vol_hpr_o == 5'd0, "R10 mute", vol_spk_o, 0);
        check(ctrl_o == 8'h40, "R10 ctrl", ctrl_o, 8'h40);
        check(sda_oe_o == 1'b0, "R12 idle release", sda_oe_o, 0);
        chk_en = 1'b1;

        // R1 R2 R3: burst write from register 1 through the control byte.
        do_start();
        send_byte(8'h9A, 0, ack); check(ack, "R1 write address ACK", ack, 1);
        send_byte(8'h01, 0, ack); mptr = 1; check(ack, "R2 pointer ACK", ack, 1);
        send_byte(8'hFF, 1, ack); check(ack, "R2 data ACK", ack, 1);
        send_byte(8'h35, 1, ack); check(ack, "R3 second data ACK", ack, 1);
        send_byte(8'h0A, 1, ack);
        send_byte(8'hFF, 1, ack); check(ack, "R9 control ACK", ack, 1);
        do_stop();
        check(ctrl_o == 8'hDF, "R9 bit5 dropped", ctrl_o, 8'hDF);
        check(vol_hpl_o == 5'h15, "R8 5-bit field", vol_hpl_o, 5'h15);

        // R4 R3 R11: read after plain START starts at register 0, runs past 4.
        do_start();
        send_byte(8'h9B, 0, ack); check(ack, "R1 read address ACK", ack, 1);
        mptr = 0;
        for (int k = 0; k < 6; k++) begin
            recv_byte(k != 5, rb);
            check(rb == model_rd(mptr), k == 0 ? "R4 first byte reg0" : "R3 read increment", rb, model_rd(mptr));
            mptr++;
        end
        // R6: after NACK the slave stays silent.
        recv_byte(0, rb);
        check(rb == 8'hFF, "R6 released after NACK", rb, 8'hFF);
        do_stop();

        // R5: pointer write then repeated START read from register 3.
        do_start();
        send_byte(8'h9A, 0, ack);
        send_byte(8'h03, 0, ack); mptr = 3;
        do_start();
        send_byte(8'h9B, 0, ack); check(ack, "R5 read after Sr ACK", ack, 1);
        recv_byte(1, rb); check(rb == model_rd(3), "R5 preset pointer", rb, model_rd(3));
        recv_byte(0, rb); check(rb == model_rd(4), "R5 then increments", rb, model_rd(4));
        do_stop();

        // R11: unmapped writes acknowledged and discarded.
        do_start();
        send_byte(8'h9A, 0, ack);
        send_byte(8'h05, 0, ack); mptr = 5;
        send_byte(8'h55, 1, ack); check(ack, "R11 unmapped write ACK", ack, 1);
        send_byte(8'h66, 1, ack);
        do_start();
        send_byte(8'h9A, 0, ack);
        send_byte(8'h00, 0, ack); mptr = 0;
        send_byte(8'h77, 1, ack); check(ack, "R11 reg0 write ACK", ack, 1);
        do_stop();

        // R1: foreign address gets no ACK and its bytes change nothing.
        do_start();
        send_byte(8'h90, 0, ack); check(!ack, "R1 foreign address NACK", ack, 0);
        send_byte(8'h02, 0, ack); check(!ack, "R1 foreign frame ignored", ack, 0);
        send_byte(8'h1F, 0, ack);
        do_stop();
        check(vol_hpl_o == 5'h15, "R1 foreign no write", vol_hpl_o, 5'h15);

        // R7: STOP in the middle of a data byte writes nothing.
        do_start();
        send_byte(8'h9A, 0, ack);
        send_byte(8'h02, 0, ack); mptr = 2;
        for (int i = 0; i < 4; i++) begin
            m_sda = 1'b0; half(); m_scl = 1'b1; half(); m_scl = 1'b0;
        end
        do_stop();
        repeat (10) @(posedge clk);
        check(vol_hpl_o == 5'h15, "R7 partial byte dropped", vol_hpl_o, 5'h15);
        check(sda_oe_o == 1'b0, "R7 released after STOP", sda_oe_o, 0);

        // R9: bit 5 alone is dropped; read back through the bus.
        do_start();
        send_byte(8'h9A, 0, ack);
        send_byte(8'h04, 0, ack); mptr = 4;
        send_byte(8'h20, 1, ack);
        do_start();
        send_byte(8'h9A, 0, ack);
        send_byte(8'h04, 0, ack); mptr = 4;
        do_start();
        send_byte(8'h9B, 0, ack);
        recv_byte(0, rb); check(rb == 8'h00, "R9 bit5 reads zero", rb, 8'h00);
        do_stop();

        check(r12_viol == 0, "R12 drive changed with SCL high", r12_viol, 0);
        repeat (20) @(posedge clk);
        finish_up();
    end
endmodule